// File: doc/BRIEF.md
# Programmable Backpressure Stall Injector

This block is a pass-through stage for a valid/acknowledge stream, placed between a producer and a consumer on a verification build. When enabled, it holds back each new beat for a number of cycles taken from a small table that is written before the run. It uses one table entry per beat, in order. Once the withheld cycles have elapsed, the beat goes through to the consumer, and the consumer's acknowledgement is passed back to the producer.

Three settings shape the injected traffic:
- An initial hold period keeps the upstream acknowledgement low for a programmed number of cycles after reset.
- A policy input selects what the upstream acknowledgement does on cycles when the producer offers nothing.
- A global enable turns the block into plain wires.

Top module: `stall_injector`

## Requirements
- R1: While `rst_n` is low, `in_ack` is 0 whatever the other inputs are.
- R2: With `cfg_enable` = 0 the block is transparent: `out_valid` = `in_valid`, `out_data` = `in_data`, `in_ack` = `out_ack` in the same cycle.
- R3: With `cfg_enable` = 1, for the first `cfg_init_stall` clock cycles after reset is released, `in_ack` and `out_valid` are 0. In the following cycle the idle policy applies again.
- R4: With `cfg_enable` = 1, the k-th accepted beat after reset (k counted from 0), for k < `cfg_tbl_len`, is withheld for exactly table[k] cycles. Its first offered cycle is cycle 0, and `out_valid` first rises in cycle table[k], carrying `in_data`.
- R5: While a beat is being withheld, `out_valid` and `in_ack` are both 0.
- R6: Beats with index k ≥ `cfg_tbl_len` pass with zero stall, regardless of what the table holds at those positions.
- R7: The stall countdown for a beat runs once, from its first offered cycle. After it expires, the beat stays on `out_valid` until `out_ack`, with no further stall, and `in_ack` equals `out_ack` in those cycles.
- R8: On enabled cycles with `in_valid` = 0 after the initial hold, `in_ack` follows `cfg_idle_mode`. The value 0 gives a constant 0, 1 gives a constant 1, and 2 gives a pattern that alternates every cycle. The value 3 behaves as 0.
- R9: Every stall count from 0 to 2^CNT_W−1 (0 to 15 by default) is applied exactly.
- R10: Table entries are written through `tbl_we`/`tbl_widx`/`tbl_wcnt` on a clock edge. They hold their value until overwritten, and reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | 1 = inject stalls, 0 = transparent |
| cfg_idle_mode | input | 2 | Idle acknowledgement policy (0 low, 1 high, 2 alternating) |
| cfg_init_stall | input | INIT_W | Cycles of forced low acknowledgement after reset |
| cfg_tbl_len | input | IDX_W | Number of loaded table entries |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | AW | Table write index |
| tbl_wcnt | input | CNT_W | Stall count to write |
| in_valid | input | 1 | Producer offers a beat |
| in_data | input | DATA_W | Producer payload |
| in_ack | output | 1 | Acknowledgement to producer |
| out_valid | output | 1 | Beat offered to consumer |
| out_data | output | DATA_W | Payload to consumer |
| out_ack | input | 1 | Acknowledgement from consumer |

## Verification
The expiry of a beat's stall countdown can fall in the same cycle as a consumer that is not ready. This case tells whether the block keeps the count finished or adds new stall on top of the backpressure. The bench provokes it by holding `out_ack` low for a set number of cycles starting exactly at the computed expiry cycle, including a zero-count beat whose expiry is its first cycle. It judges the result by requiring `out_valid` to stay high with stable data and `in_ack` to remain 0 until the cycle `out_ack` rises.

// File: rtl/sti_pkg.sv
`timescale 1ns/1ps
package sti_pkg;
   typedef enum logic [1:0] {
      IDLE_NACK   = 2'd0,
      IDLE_ACK    = 2'd1,
      IDLE_TOGGLE = 2'd2,
      IDLE_RSVD   = 2'd3
   } idle_pol_e;
endpackage

// File: rtl/sti_table.sv
`timescale 1ns/1ps
module sti_table #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    widx,
   input  logic [CNT_W-1:0] wcnt,
   input  logic [IDX_W-1:0] ridx,
   output logic [CNT_W-1:0] rcnt
);
   logic [CNT_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (we && widx == AW'(i))
            mem[i] <= wcnt;
      end
   end

   always_comb begin
      rcnt = '0;
      for (int i = 0; i < DEPTH; i++)
         if (ridx == IDX_W'(i))
            rcnt = mem[i];
   end
endmodule

// File: rtl/sti_init_gate.sv
`timescale 1ns/1ps
module sti_init_gate #(
   parameter int INIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INIT_W-1:0] limit,
   output logic              busy
);
   logic [INIT_W-1:0] cnt;

   assign busy = (cnt < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (busy)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sti_idle_ack.sv
`timescale 1ns/1ps
module sti_idle_ack
   import sti_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   output logic       idle_ack
);
   logic tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog <= 1'b0;
      else
         tog <= ~tog;
   end

   always_comb begin
      unique case (idle_pol_e'(mode))
         IDLE_ACK:    idle_ack = 1'b1;
         IDLE_TOGGLE: idle_ack = tog;
         default:     idle_ack = 1'b0;
      endcase
   end
endmodule

// File: rtl/sti_beat_ctrl.sv
`timescale 1ns/1ps
module sti_beat_ctrl #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             in_valid,
   input  logic             out_ack,
   input  logic [IDX_W-1:0] tbl_len,
   input  logic [CNT_W-1:0] tbl_cnt,
   output logic [IDX_W-1:0] beat_idx,
   output logic             fwd
);
   logic             holding;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] rem_now;
   logic             offer;

   assign offer   = active && in_valid;
   assign rem_now = holding ? remain : ((beat_idx < tbl_len) ? tbl_cnt : '0);
   assign fwd     = offer && (rem_now == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         holding  <= 1'b0;
         remain   <= '0;
         beat_idx <= '0;
      end else if (offer) begin
         if (fwd && out_ack) begin
            holding <= 1'b0;
            remain  <= '0;
            if (beat_idx != '1)
               beat_idx <= beat_idx + 1'b1;
         end else begin
            holding <= 1'b1;
            remain  <= fwd ? '0 : rem_now - 1'b1;
         end
      end
   end
endmodule

// File: rtl/stall_injector.sv
`timescale 1ns/1ps
module stall_injector #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4,
   parameter int INIT_W = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IDX_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_idle_mode,
   input  logic [INIT_W-1:0] cfg_init_stall,
   input  logic [IDX_W-1:0]  cfg_tbl_len,
   input  logic              tbl_we,
   input  logic [AW-1:0]     tbl_widx,
   input  logic [CNT_W-1:0]  tbl_wcnt,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ack,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ack
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("stall_injector: DEPTH must be at least 1");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("stall_injector: CNT_W must cover counts up to 10");
   end
   if (DATA_W < 1 || INIT_W < 1) begin : g_bad_w
      $error("stall_injector: widths must be positive");
   end

   logic             init_busy;
   logic             idle_ack;
   logic             fwd;
   logic [IDX_W-1:0] beat_idx;
   logic [CNT_W-1:0] tbl_cnt;

   sti_table #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_widx),
      .wcnt(tbl_wcnt), .ridx(beat_idx), .rcnt(tbl_cnt)
   );

   sti_init_gate #(.INIT_W(INIT_W)) u_init (
      .clk(clk), .rst_n(rst_n), .limit(cfg_init_stall), .busy(init_busy)
   );

   sti_idle_ack u_idle (
      .clk(clk), .rst_n(rst_n), .mode(cfg_idle_mode), .idle_ack(idle_ack)
   );

   sti_beat_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .active(cfg_enable && !init_busy),
      .in_valid(in_valid), .out_ack(out_ack), .tbl_len(cfg_tbl_len),
      .tbl_cnt(tbl_cnt), .beat_idx(beat_idx), .fwd(fwd)
   );

   assign out_data  = in_data;
   assign out_valid = cfg_enable ? fwd : in_valid;

   always_comb begin
      if (!rst_n)
         in_ack = 1'b0;
      else if (!cfg_enable)
         in_ack = out_ack;
      else if (init_busy)
         in_ack = 1'b0;
      else if (in_valid)
         in_ack = fwd && out_ack;
      else
         in_ack = idle_ack;
   end
endmodule

// File: rtl/sti_checker.sv
`timescale 1ns/1ps
module sti_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [1:0]        mode,
   input logic              init_busy,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              in_ack,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_ack
);
   always_comb begin
      if (rst_n === 1'b0)
         assert_ack_low_in_reset_R1: assert (in_ack == 1'b0);
   end

   assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (out_valid == in_valid && in_ack == out_ack && out_data == in_data));

   assert_init_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en && init_busy |-> !in_ack && !out_valid);

   assert_stall_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en && in_valid && !out_valid |-> !in_ack);

   assert_ack_needs_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && in_valid && in_ack |-> out_valid && out_ack);

   assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && out_valid && !out_ack |=> out_valid);

   assert_idle_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !in_valid && mode == 2'd0 |-> !in_ack);

   assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !init_busy && !in_valid && mode == 2'd1 |-> in_ack);
endmodule

bind stall_injector sti_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(cfg_enable), .mode(cfg_idle_mode),
   .init_busy(init_busy), .in_valid(in_valid), .in_data(in_data),
   .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data),
   .out_ack(out_ack)
);

// File: tb/sim_stall_injector.sv
`timescale 1ns/1ps
module sim_stall_injector;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 8;
   localparam int CNT_W  = 4;
   localparam int INIT_W = 8;
   localparam int AW     = 3;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_enable = 1'b1;
   logic [1:0]        cfg_idle_mode = 2'd1;
   logic [INIT_W-1:0] cfg_init_stall = 8'd5;
   logic [IDX_W-1:0]  cfg_tbl_len = '0;
   logic              tbl_we = 1'b0;
   logic [AW-1:0]     tbl_widx = '0;
   logic [CNT_W-1:0]  tbl_wcnt = '0;
   logic              in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic              in_ack;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;
   logic              out_ack = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   stall_injector #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .INIT_W(INIT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_idle_mode(cfg_idle_mode),
      .cfg_init_stall(cfg_init_stall), .cfg_tbl_len(cfg_tbl_len), .tbl_we(tbl_we),
      .tbl_widx(tbl_widx), .tbl_wcnt(tbl_wcnt), .in_valid(in_valid), .in_data(in_data),
      .in_ack(in_ack), .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input int idx, input int cnt);
      @(negedge clk);
      tbl_we = 1'b1; tbl_widx = AW'(idx); tbl_wcnt = CNT_W'(cnt);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // one beat: expected stall, then 'hold' cycles of consumer backpressure
   task automatic send(input int data, input int stall, input int hold, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_data = DATA_W'(data);
      for (int c = 0; c < 64; c++) begin
         if (c > 0) @(negedge clk);
         out_ack = (c >= stall + hold);
         #1;
         if (c < stall) begin
            chk(!out_valid, {req, " stalled out_valid"}, int'(out_valid), 0);
            chk(!in_ack, "R5 in_ack during stall", int'(in_ack), 0);
         end else begin
            chk(out_valid, {req, " out_valid after stall"}, int'(out_valid), 1);
            chk(out_data == DATA_W'(data), {req, " out_data"}, int'(out_data), data);
            chk(in_ack == out_ack, "R7 in_ack follows out_ack", int'(in_ack), int'(out_ack));
            if (out_ack) break;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; out_ack = 1'b0;
   endtask

   task automatic idle_check(input int mode);
      bit prev;
      @(negedge clk);
      cfg_idle_mode = 2'(mode); in_valid = 1'b0;
      #1 prev = in_ack;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         #1;
         if (mode == 2)
            chk(in_ack != prev, "R8 alternating idle ack", int'(in_ack), int'(!prev));
         else
            chk(in_ack == (mode == 1), "R8 idle ack level", int'(in_ack), int'(mode == 1));
         prev = in_ack;
      end
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      if (!finished) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset holds in_ack low, enabled and transparent
      in_valid = 1'b1; out_ack = 1'b1;
      repeat (2) @(negedge clk);
      #1 chk(!in_ack, "R1 reset enabled", int'(in_ack), 0);
      cfg_enable = 1'b0;
      #1 chk(!in_ack, "R1 reset transparent", int'(in_ack), 0);
      @(negedge clk);
      cfg_enable = 1'b1; in_valid = 1'b0; out_ack = 1'b0; cfg_idle_mode = 2'd1;
      rst_n = 1'b1;
      // R3: 5 cycles of forced low ack, then idle policy (ack high)
      for (int c = 0; c <= 5; c++) begin
         if (c > 0) @(negedge clk);
         #1;
         chk(in_ack == (c == 5), "R3 initial hold", int'(in_ack), int'(c == 5));
         chk(!out_valid, "R3 no output during hold", int'(out_valid), 0);
      end
      // R10: load table, length 6
      wr(0, 4); wr(1, 5); wr(2, 6); wr(3, 0); wr(4, 15); wr(5, 1); wr(6, 2); wr(7, 3);
      cfg_tbl_len = 4'd6;
      send(8'hA0, 4, 0, "R4 beat0");
      idle_check(0);
      send(8'hA1, 5, 2, "R7 beat1 backpressure");
      idle_check(2);
      send(8'hA2, 6, 0, "R10 beat2");
      send(8'hA3, 0, 3, "R7 zero stall backpressure");
      send(8'hA4, 15, 0, "R9 max count");
      send(8'hA5, 1, 1, "R4 beat5");
      send(8'hA6, 0, 0, "R6 past table");
      send(8'hA7, 0, 0, "R6 past table");
      idle_check(1);
      idle_check(3);
      // R2: transparent sweep
      @(negedge clk);
      cfg_enable = 1'b0;
      for (int v = 0; v < 4; v++) begin
         @(negedge clk);
         in_valid = v[0]; out_ack = v[1]; in_data = DATA_W'(8'h50 + v);
         #1;
         chk(out_valid == in_valid, "R2 out_valid", int'(out_valid), int'(in_valid));
         chk(out_data == in_data, "R2 out_data", int'(out_data), int'(in_data));
         chk(in_ack == out_ack, "R2 in_ack", int'(in_ack), int'(out_ack));
      end
      @(negedge clk);
      in_valid = 1'b0; out_ack = 1'b0; cfg_enable = 1'b1;
      // R9: every count 0..15, two reset runs of 8 beats
      for (int r = 0; r < 2; r++) begin
         @(negedge clk);
         rst_n = 1'b0; cfg_init_stall = '0;
         @(negedge clk);
         rst_n = 1'b1;
         for (int i = 0; i < DEPTH; i++) wr(i, 8 * r + i);
         cfg_tbl_len = 4'd8;
         for (int i = 0; i < DEPTH; i++)
            send(16 * r + i, 8 * r + i, i % 2, "R9 count sweep");
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule